// File: doc/BRIEF.md
# Frame-Synchronous Serial Output Flags

This block keeps two general-purpose flag outputs of a synchronous serial port in step with the transmitted data. Software writes the flag bits into a holding register, normally after polling for an empty transmitter and before writing the next transmit word. The held bits move into a staging stage when the transmit word is loaded into the shift register. At the next frame boundary (normal mode) or the next slot boundary (network mode), they become the values on the pins.

Three multifunction pins each have a direction bit. A flag pin is enabled as an output only when its direction bit is 1 and the port runs in synchronous clock mode. The third pin's enable follows its direction bit alone. Release of the flags depends only on frame timing, never on any transmit or receive enable. A hardware reset (asynchronous) or a software reset (synchronous) clears the flags and the direction bits.

Top module: `sof_flags`

## Requirements
- R1: After hardware reset, `flag_out` is 0 and every bit of `pin_oe` is 0.
- R2: `pin_oe[i]` equals direction bit i AND `sync_mode` for the flag pins (i = 0, 1). `pin_oe[2]` equals direction bit 2. A direction bit changes only on a `dir_we` write or a reset. When a pin is an input, its held flag value is kept.
- R3: A flag write on its own leaves `flag_out` unchanged. `flag_out` changes only on the clock edge that samples a release boundary while a staged value exists, or on a reset.
- R4: With `network_mode` = 0, only `frame_start` releases a staged value. `slot_start` alone has no effect.
- R5: With `network_mode` = 1, `slot_start` or `frame_start` releases a staged value.
- R6: Several flag writes before a `tx_load` leave only the last written value to be transferred.
- R7: When `tx_load` and a release boundary fall in the same cycle, the value being loaded appears on `flag_out` after that edge.
- R8: A release boundary with no staged value leaves `flag_out` unchanged. Each staged value is released once.
- R9: `soft_rst` clears the flags, the staged value and the direction bits on the next clock edge.
- R10: A flag write in the same cycle as `tx_load` is included in the transferred value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| flag_we | input | 1 | Host write strobe for the flag holding register |
| flag_wdata | input | NF | Flag values to hold |
| dir_we | input | 1 | Host write strobe for direction bits |
| dir_wdata | input | NP | Direction bits, 1 = output |
| sync_mode | input | 1 | Synchronous clock mode |
| network_mode | input | 1 | 1 = network (slot) mode, 0 = normal mode |
| tx_load | input | 1 | Transmit word enters the shift register |
| frame_start | input | 1 | Start-of-frame strobe |
| slot_start | input | 1 | Start-of-slot strobe |
| flag_out | output | NF | Values presented on the flag pins |
| pin_oe | output | NP | Output enables of the multifunction pins |

## Verification
The embedded properties check on every cycle that the flag pins and direction bits move only at a boundary, a write or a reset. They also check that a slot strobe in normal mode is ignored, that a release empties the staging stage, and that the flag enables stay low outside synchronous mode. Only the bench scenarios can show which value is released: the last write, the same-cycle write, the same-cycle load-and-boundary case, and the full sweep of direction and mode combinations against the enables.

// File: rtl/sof_pkg.sv
package sof_pkg;
    typedef enum logic {
        BND_FRAME = 1'b0,
        BND_SLOT  = 1'b1
    } bnd_sel_e;

    function automatic logic boundary_hit(bnd_sel_e sel, logic frm, logic slt);
        return (sel == BND_SLOT) ? (frm | slt) : frm;
    endfunction
endpackage

// File: rtl/sof_hold.sv
module sof_hold #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          we,
    input  logic [NF-1:0] wdata,
    input  logic          load,
    input  logic          take,
    output logic [NF-1:0] stage_val,
    output logic          stage_vld
);
    typedef struct packed {
        logic [NF-1:0] hold;
        logic [NF-1:0] pend;
        logic          vld;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic [NF-1:0] hold_new;

    always_comb begin
        st_d     = st_q;
        hold_new = we ? wdata : st_q.hold;
        st_d.hold = hold_new;
        if (load && !take) begin
            st_d.pend = hold_new;
            st_d.vld  = 1'b1;
        end else if (take) begin
            st_d.vld  = 1'b0;
        end
        if (soft_rst) begin
            st_d = '0;
        end
        stage_val = load ? hold_new : st_q.pend;
        stage_vld = load | st_q.vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HOLD_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !soft_rst) |=> (st_q.hold == $past(wdata)));  // R6
    AST_STAGE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !soft_rst) |=> !st_q.vld);  // R8
endmodule

// File: rtl/sof_release.sv
module sof_release
    import sof_pkg::*;
#(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          network_mode,
    input  logic          frame_start,
    input  logic          slot_start,
    input  logic [NF-1:0] stage_val,
    input  logic          stage_vld,
    output logic          take,
    output logic [NF-1:0] flag_q
);
    typedef struct packed {
        logic [NF-1:0] drive;
    } rel_st_t;

    rel_st_t  st_d, st_q;
    bnd_sel_e sel;
    logic     bnd;

    always_comb begin
        sel  = network_mode ? BND_SLOT : BND_FRAME;
        bnd  = boundary_hit(sel, frame_start, slot_start);
        take = bnd & stage_vld;
        st_d = st_q;
        if (take) begin
            st_d.drive = stage_val;
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.drive;

    AST_FLAG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_q) |-> $past(take || soft_rst));  // R3
    AST_NORMAL_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!network_mode && slot_start && !frame_start && !soft_rst) |=> $stable(flag_q));  // R4
    AST_FLAG_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (flag_q == '0));  // R9
endmodule

// File: rtl/sof_dir.sv
module sof_dir #(
    parameter int NF = 2,
    parameter int NP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          dir_we,
    input  logic [NP-1:0] dir_wdata,
    input  logic          sync_mode,
    output logic [NP-1:0] pin_oe
);
    typedef struct packed {
        logic [NP-1:0] dir;
    } dir_st_t;

    dir_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dir_we) begin
            st_d.dir = dir_wdata;
        end
        if (soft_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NP; i++) begin : g_oe
        if (i < NF) begin : g_flag
            assign pin_oe[i] = st_q.dir[i] & sync_mode;
        end else begin : g_plain
            assign pin_oe[i] = st_q.dir[i];
        end
    end

    AST_DIR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.dir) |-> $past(dir_we || soft_rst));  // R2
    AST_DIR_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q.dir == '0));  // R9
endmodule

// File: rtl/sof_flags.sv
module sof_flags #(
    parameter int NF = 2,
    parameter int NP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          flag_we,
    input  logic [NF-1:0] flag_wdata,
    input  logic          dir_we,
    input  logic [NP-1:0] dir_wdata,
    input  logic          sync_mode,
    input  logic          network_mode,
    input  logic          tx_load,
    input  logic          frame_start,
    input  logic          slot_start,
    output logic [NF-1:0] flag_out,
    output logic [NP-1:0] pin_oe
);
    logic [NF-1:0] stage_val;
    logic          stage_vld;
    logic          take;

    sof_hold #(.NF(NF)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .we        (flag_we),
        .wdata     (flag_wdata),
        .load      (tx_load),
        .take      (take),
        .stage_val (stage_val),
        .stage_vld (stage_vld)
    );

    sof_release #(.NF(NF)) u_rel (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .network_mode (network_mode),
        .frame_start  (frame_start),
        .slot_start   (slot_start),
        .stage_val    (stage_val),
        .stage_vld    (stage_vld),
        .take         (take),
        .flag_q       (flag_out)
    );

    sof_dir #(.NF(NF), .NP(NP)) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .dir_we    (dir_we),
        .dir_wdata (dir_wdata),
        .sync_mode (sync_mode),
        .pin_oe    (pin_oe)
    );

    AST_OE_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |-> (pin_oe[NF-1:0] == '0));  // R2
endmodule

// File: tb/sof_flags_test.sv
module sof_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       flag_we = 1'b0;
    logic [1:0] flag_wdata = '0;
    logic       dir_we = 1'b0;
    logic [2:0] dir_wdata = '0;
    logic       sync_mode = 1'b0;
    logic       network_mode = 1'b0;
    logic       tx_load = 1'b0;
    logic       frame_start = 1'b0;
    logic       slot_start = 1'b0;
    logic [1:0] flag_out;
    logic [2:0] pin_oe;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_flag = '0;

    always #4 clk = ~clk;

    sof_flags uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .dir_we(dir_we), .dir_wdata(dir_wdata),
        .sync_mode(sync_mode), .network_mode(network_mode),
        .tx_load(tx_load), .frame_start(frame_start), .slot_start(slot_start),
        .flag_out(flag_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: strobes set at negedge, sampled at posedge, cleared at next negedge
    task automatic cyc(input logic we, input logic [1:0] wd, input logic ld,
                       input logic fr, input logic sl);
        flag_we = we; flag_wdata = wd; tx_load = ld;
        frame_start = fr; slot_start = sl;
        @(negedge clk);
        flag_we = 1'b0; tx_load = 1'b0; frame_start = 1'b0; slot_start = 1'b0;
    endtask

    task automatic set_dir(input logic [2:0] d);
        dir_we = 1'b1; dir_wdata = d;
        @(negedge clk);
        dir_we = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flag_out", flag_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag_out after release", flag_out, 0);

        // R2: full sweep of direction and sync mode
        for (int d = 0; d < 8; d++) begin
            for (int s = 0; s < 2; s++) begin
                sync_mode = s[0];
                set_dir(d[2:0]);
                chk("R2 oe sweep", pin_oe,
                    {d[2], d[1] & s[0], d[0] & s[0]});
            end
        end

        // R3/R4/R5: every value in both modes
        sync_mode = 1'b1;
        for (int n = 0; n < 2; n++) begin
            network_mode = n[0];
            for (int v = 0; v < 4; v++) begin
                logic [1:0] nv;
                nv = v[1:0] ^ 2'b11;
                cyc(1'b1, nv, 1'b0, 1'b0, 1'b0);
                chk("R3 write alone", flag_out, exp_flag);
                cyc(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
                chk("R3 load alone", flag_out, exp_flag);
                if (n == 0) begin
                    cyc(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
                    chk("R4 slot ignored in normal", flag_out, exp_flag);
                    cyc(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
                    exp_flag = nv;
                    chk("R4 frame release", flag_out, exp_flag);
                end else begin
                    cyc(1'b0, 2'b00, 1'b0, 1'b0, (v % 2) == 0);
                    if (v % 2 != 0) cyc(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
                    exp_flag = nv;
                    chk("R5 slot/frame release", flag_out, exp_flag);
                end
                cyc(1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
                chk("R8 boundary without staged value", flag_out, exp_flag);
            end
        end

        // R6: last write wins
        network_mode = 1'b0;
        cyc(1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        exp_flag = 2'b10;
        chk("R6 last write", flag_out, exp_flag);

        // R10: write in the load cycle
        cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        exp_flag = 2'b01;
        chk("R10 same-cycle write", flag_out, exp_flag);

        // R7: load and boundary together, both modes
        for (int n = 0; n < 2; n++) begin
            network_mode = n[0];
            for (int v = 0; v < 4; v++) begin
                cyc(1'b1, v[1:0], 1'b0, 1'b0, 1'b0);
                cyc(1'b0, 2'b00, 1'b1, n == 0, n == 1);
                exp_flag = v[1:0];
                chk("R7 load at boundary", flag_out, exp_flag);
            end
        end

        // R2: input pin keeps flag value
        set_dir(3'b000);
        chk("R2 oe off", pin_oe, 0);
        chk("R2 value kept", flag_out, exp_flag);

        // R9: soft reset
        set_dir(3'b111);
        cyc(1'b1, 2'b01, 1'b1, 1'b0, 1'b0);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        exp_flag = 2'b00;
        chk("R9 flags cleared", flag_out, 0);
        chk("R9 dirs cleared", pin_oe, 0);
        cyc(1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        chk("R9 staged value cleared", flag_out, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule